// File: doc/BRIEF.md
# Multi-Source Programmable Interrupt Counter

This block raises an interrupt request after a programmed number of events. An 8-bit down-counting prescaler sits in front of an 8-bit down-counting main counter. Each underflow of the prescaler decrements the main counter. An underflow of the main counter sets the interrupt line, and the line stays high until software acknowledges it.

The event that drives the prescaler is chosen from four single-cycle strobes:
- a CPU bus cycle;
- a rising edge of address line 12 of the picture processor;
- a change of the picture processor's address, which counts twice;
- a CPU write.

Software programs the block through a small write port with eight register slots. The values loaded into the prescaler and the counter are first XORed with a key that software sets. The address decode that places this port in a system map lies outside the block.

Top module: `irq_event_counter`

## Requirements
- R1: A synchronous active-low reset clears every register: irq is low, counting is disabled, the source select is 0, the key is 0, and the prescaler and counter are both 0.
- R2: Bits [1:0] of a write to slot 1 select the source. 0 selects CPU cycles (ev_cpu_cycle), 1 selects address-line-12 rises (ev_a12_rise), 2 selects address changes (ev_addr_change) and 3 selects CPU writes (ev_cpu_write). Strobes on the three sources that are not selected have no effect.
- R3: One pulse of the address-change source gives two prescaler ticks. One pulse of any other source gives one tick.
- R4: On a tick, a nonzero prescaler decrements. A zero prescaler wraps to 255 and decrements the counter. From a prescaler value P and a counter value C, the counter underflows on tick P+1+256*C.
- R5: An underflow of the counter sets irq one clock after the tick. irq then stays high, through further ticks, until it is acknowledged.
- R6: A write to slot 6 sets the key. A write to slot 4 loads the prescaler with data XOR key, and a write to slot 5 loads the counter with data XOR key.
- R7: A write to slot 0 sets the enable from data bit 0. When bit 0 is 0, the write also clears the prescaler and acknowledges irq. When bit 0 is 1, irq is left as it is.
- R8: A write to slot 2 disables counting, clears the prescaler and acknowledges irq. A write to slot 3 enables counting.
- R9: While counting is disabled, strobes are ignored and the prescaler and counter keep their values.
- R10: In the cycle of a register write, ticks are first applied to the state held before the write, and the write's effect then takes priority. An acknowledge in the same cycle as an underflow leaves irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register slot, 0 to 7 |
| wr_data | input | 8 | Register write data |
| ev_cpu_cycle | input | 1 | Pulse per CPU bus cycle |
| ev_a12_rise | input | 1 | Pulse per rise of address line 12 of the picture processor |
| ev_addr_change | input | 1 | Pulse per change of the picture processor's address |
| ev_cpu_write | input | 1 | Pulse per CPU write |
| irq | output | 1 | Interrupt request, active high, held until acknowledged |

## Verification
The prescaler and the counter are visible only through the timing of irq. A wrong tick count, a wrong source select or a wrong key shows up as irq rising a different number of strobes after the load. For a low prescaler load this is within a few strobes; for a nonzero counter load it is up to hundreds of strobes later. A lost acknowledge or a lost clear shows at once as irq staying high, or as irq rising early on the next strobe. For this reason, each case loads small values and checks irq both one strobe before and exactly at the expected tick.

// File: rtl/irqc_pkg.sv
// Package: shared register slots and source encoding for the interrupt counter.
// Assumes: the slot numbers below are the decode used by the register file.
package irqc_pkg;

    typedef enum logic [1:0] {
        SRC_CPU_CYCLE   = 2'd0,
        SRC_A12_RISE    = 2'd1,
        SRC_ADDR_CHANGE = 2'd2,
        SRC_CPU_WRITE   = 2'd3
    } irq_src_e;

    localparam logic [2:0] SLOT_ENABLE  = 3'd0;
    localparam logic [2:0] SLOT_SOURCE  = 3'd1;
    localparam logic [2:0] SLOT_DISABLE = 3'd2;
    localparam logic [2:0] SLOT_ARM     = 3'd3;
    localparam logic [2:0] SLOT_PRES    = 3'd4;
    localparam logic [2:0] SLOT_COUNT   = 3'd5;
    localparam logic [2:0] SLOT_KEY     = 3'd6;

endpackage

// File: rtl/irqc_regs.sv
// Module: irqc_regs
// Decodes register writes into held state (enable, source, key) and into
// single-cycle strobes (load prescaler, load counter, clear prescaler, ack).
// Assumes: wr_en is a single-cycle write qualifier; slot 7 is unused.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              enable,
    output irq_src_e          src,
    output logic              ld_pres,
    output logic              ld_cnt,
    output logic [DATA_W-1:0] ld_value,
    output logic              clr_pres,
    output logic              ack
);

    logic [DATA_W-1:0] key_q;
    logic              hit_enable, hit_source, hit_disable, hit_arm, hit_key;

    // Slot decode of the current write.
    always_comb begin
        hit_enable  = wr_en && (wr_addr == SLOT_ENABLE);
        hit_source  = wr_en && (wr_addr == SLOT_SOURCE);
        hit_disable = wr_en && (wr_addr == SLOT_DISABLE);
        hit_arm     = wr_en && (wr_addr == SLOT_ARM);
        hit_key     = wr_en && (wr_addr == SLOT_KEY);
        ld_pres     = wr_en && (wr_addr == SLOT_PRES);
        ld_cnt      = wr_en && (wr_addr == SLOT_COUNT);
    end

    // Strobes to the counting core; loads use the key held before this write.
    always_comb begin
        ld_value = wr_data ^ key_q;
        clr_pres = hit_disable || (hit_enable && !wr_data[0]);
        ack      = clr_pres;
    end

    // Held register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            src    <= SRC_CPU_CYCLE;
            key_q  <= '0;
        end else begin
            if (hit_enable)  enable <= wr_data[0];
            if (hit_disable) enable <= 1'b0;
            if (hit_arm)     enable <= 1'b1;
            if (hit_source)  src    <= irq_src_e'(wr_data[1:0]);
            if (hit_key)     key_q  <= wr_data;
        end
    end

    // R6: the key changes only on a write to its own slot.
    a_r6_key_only_own_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_key |=> $stable(key_q));

    // R8: a disable write leaves counting off.
    a_r8_disable_takes: assert property (@(posedge clk) disable iff (!rst_n)
        hit_disable |=> !enable);

endmodule

// File: rtl/irqc_event_sel.sv
// Module: irqc_event_sel
// Picks the strobe of the selected source and turns it into a tick count
// for this cycle. The address-change source weighs ADDR_CHANGE_TICKS.
// Assumes: strobes are synchronous single-cycle pulses.
module irqc_event_sel
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_CHANGE_TICKS = 2,
    localparam int unsigned MAX_TICKS = (ADDR_CHANGE_TICKS > 1) ? ADDR_CHANGE_TICKS : 1,
    localparam int unsigned TICK_W    = $clog2(MAX_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irq_src_e          src,
    input  logic              ev_cpu_cycle,
    input  logic              ev_a12_rise,
    input  logic              ev_addr_change,
    input  logic              ev_cpu_write,
    output logic [TICK_W-1:0] ticks
);

    localparam logic [TICK_W-1:0] ONE_TICK = TICK_W'(1);
    localparam logic [TICK_W-1:0] AC_TICKS = TICK_W'(ADDR_CHANGE_TICKS);

    // Tick count for this cycle from the selected source only.
    always_comb begin
        ticks = '0;
        unique case (src)
            SRC_CPU_CYCLE:   if (ev_cpu_cycle)   ticks = ONE_TICK;
            SRC_A12_RISE:    if (ev_a12_rise)    ticks = ONE_TICK;
            SRC_ADDR_CHANGE: if (ev_addr_change) ticks = AC_TICKS;
            SRC_CPU_WRITE:   if (ev_cpu_write)   ticks = ONE_TICK;
            default:         ticks = '0;
        endcase
    end

    // R2: no ticks without a strobe on some source.
    a_r2_tick_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks != '0) |-> (ev_cpu_cycle || ev_a12_rise || ev_addr_change || ev_cpu_write));

endmodule

// File: rtl/irqc_core.sv
// Module: irqc_core
// Prescaler and main counter, both counting down, with the interrupt flag.
// Applies up to MAX_TICKS ticks per cycle, then lets register strobes override.
// Assumes: ld_pres, ld_cnt and clr_pres are never active together.
module irqc_core #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MAX_TICKS = 2,
    localparam int unsigned TICK_W   = $clog2(MAX_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [TICK_W-1:0] ticks,
    input  logic              ld_pres,
    input  logic              ld_cnt,
    input  logic [DATA_W-1:0] ld_value,
    input  logic              clr_pres,
    input  logic              ack,
    output logic              irq
);

    logic [DATA_W-1:0] pres_q, cnt_q;
    logic [DATA_W-1:0] pres_st, cnt_st;
    logic              fire;

    // Apply this cycle's ticks one after another to the held state.
    always_comb begin
        pres_st = pres_q;
        cnt_st  = cnt_q;
        fire    = 1'b0;
        for (int i = 0; i < MAX_TICKS; i++) begin
            if (enable && (i < int'(ticks))) begin
                if (pres_st == '0) begin
                    pres_st = '1;
                    if (cnt_st == '0) fire = 1'b1;
                    cnt_st = cnt_st - 1'b1;
                end else begin
                    pres_st = pres_st - 1'b1;
                end
            end
        end
    end

    // State update: register strobes take priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
            cnt_q  <= '0;
            irq    <= 1'b0;
        end else begin
            pres_q <= ld_pres ? ld_value : (clr_pres ? '0 : pres_st);
            cnt_q  <= ld_cnt  ? ld_value : cnt_st;
            irq    <= ack ? 1'b0 : (irq || fire);
        end
    end

    // R5: irq is held until acknowledged.
    a_r5_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R10: an acknowledge always leaves irq low.
    a_r10_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq);

    // R9: with counting off and no write, the prescaler holds.
    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !ld_pres && !clr_pres) |=> $stable(pres_q));

    // R5: irq rises only after a cycle in which counting was on.
    a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(enable));

endmodule

// File: rtl/irq_event_counter.sv
// Module: irq_event_counter
// Top: register file, source selector and counting core.
// Assumes: all inputs are synchronous to clk; address decode is external.
module irq_event_counter
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W            = 8,
    parameter int unsigned ADDR_CHANGE_TICKS = 2,
    localparam int unsigned MAX_TICKS = (ADDR_CHANGE_TICKS > 1) ? ADDR_CHANGE_TICKS : 1,
    localparam int unsigned TICK_W    = $clog2(MAX_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_cpu_cycle,
    input  logic              ev_a12_rise,
    input  logic              ev_addr_change,
    input  logic              ev_cpu_write,
    output logic              irq
);

    logic              enable, ld_pres, ld_cnt, clr_pres, ack;
    irq_src_e          src;
    logic [DATA_W-1:0] ld_value;
    logic [TICK_W-1:0] ticks;

    irqc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .enable(enable), .src(src), .ld_pres(ld_pres),
        .ld_cnt(ld_cnt), .ld_value(ld_value), .clr_pres(clr_pres), .ack(ack)
    );

    irqc_event_sel #(.ADDR_CHANGE_TICKS(ADDR_CHANGE_TICKS)) u_sel (
        .clk(clk), .rst_n(rst_n), .src(src), .ev_cpu_cycle(ev_cpu_cycle),
        .ev_a12_rise(ev_a12_rise), .ev_addr_change(ev_addr_change),
        .ev_cpu_write(ev_cpu_write), .ticks(ticks)
    );

    irqc_core #(.DATA_W(DATA_W), .MAX_TICKS(MAX_TICKS)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ticks(ticks),
        .ld_pres(ld_pres), .ld_cnt(ld_cnt), .ld_value(ld_value),
        .clr_pres(clr_pres), .ack(ack), .irq(irq)
    );

endmodule

// File: tb/irq_event_counter_tb.sv
module irq_event_counter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] ev = '0;   // index = source code: 0 cycle, 1 a12, 2 addr change, 3 write
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    irq_event_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ev_cpu_cycle(ev[0]), .ev_a12_rise(ev[1]),
        .ev_addr_change(ev[2]), .ev_cpu_write(ev[3]), .irq(irq)
    );

    // {source, prescaler load, pulses until irq}; counter loaded with 0
    localparam logic [23:0] VEC [5] = '{
        {8'd0, 8'd3, 8'd4},
        {8'd1, 8'd7, 8'd8},
        {8'd2, 8'd5, 8'd3},
        {8'd2, 8'd4, 8'd3},
        {8'd3, 8'd0, 8'd1}
    };

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk); ev[s] = 1'b1;
        @(negedge clk); ev = '0;
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(irq, 1'b0, "R1 reset irq low");

        // Table: source select and tick weight per source
        for (int i = 0; i < 5; i++) begin
            int s, p, n;
            s = int'(VEC[i][23:16]); p = int'(VEC[i][15:8]); n = int'(VEC[i][7:0]);
            wr(3'd2, 8'h00); wr(3'd6, 8'h00); wr(3'd1, 8'(s));
            wr(3'd4, 8'(p)); wr(3'd5, 8'h00); wr(3'd3, 8'h00);
            for (int k = 0; k < n - 1; k++) pulse(s);
            for (int o = 0; o < 4; o++) if (o != s) pulse(o);
            check(irq, 1'b0, "R2/R3 no irq before last selected pulse");
            pulse(s);
            check(irq, 1'b1, "R3/R4 irq at expected pulse");
        end

        // R6: key XOR on loads, P=0 C=1 -> 257 ticks
        wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd6, 8'hFF);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFE); wr(3'd3, 8'h00);
        for (int k = 0; k < 256; k++) pulse(0);
        check(irq, 1'b0, "R6/R4 no irq after 256 ticks");
        pulse(0);
        check(irq, 1'b1, "R6/R4 irq at tick 257");

        // R5 held, R7 ack behaviour
        pulse(0); pulse(0);
        check(irq, 1'b1, "R5 irq held through ticks");
        wr(3'd0, 8'h01);
        check(irq, 1'b1, "R7 enable write with bit0=1 keeps irq");
        wr(3'd0, 8'h00);
        check(irq, 1'b0, "R7 bit0=0 acknowledges");

        // R7 prescaler clear
        wr(3'd6, 8'h00); wr(3'd4, 8'd5); wr(3'd5, 8'h00); wr(3'd0, 8'h01);
        pulse(0); pulse(0); pulse(0);
        check(irq, 1'b0, "R7 partial count no irq");
        wr(3'd0, 8'h00); wr(3'd0, 8'h01);
        pulse(0);
        check(irq, 1'b1, "R7 cleared prescaler fires on next tick");

        // R8 ack by slot 2, R9 disabled ignores strobes
        wr(3'd2, 8'h00);
        check(irq, 1'b0, "R8 slot 2 acknowledges");
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        pulse(0); pulse(0); pulse(0);
        check(irq, 1'b0, "R9 disabled strobes ignored");
        wr(3'd3, 8'h00);
        pulse(0);
        check(irq, 1'b1, "R9/R8 state kept, slot 3 enables");

        // R10: acknowledge coincident with underflow
        wr(3'd2, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd3, 8'h00);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; ev[0] = 1'b1;
        @(negedge clk); wr_en = 1'b0; ev = '0;
        check(irq, 1'b0, "R10 ack wins over same-cycle underflow");

        // R1: reset clears irq and key
        wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd3, 8'h00); pulse(0);
        check(irq, 1'b1, "R1 setup irq high");
        wr(3'd6, 8'h33);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check(irq, 1'b0, "R1 reset clears irq");
        wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd3, 8'h00); pulse(0);
        check(irq, 1'b1, "R1 key reset to zero");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule